// File: doc/BRIEF.md
# DDR2 Multi-Rank Power-Up Sequencer

This block walks a DDR2 memory interface from power-up to a usable state. A one-cycle start pulse is sampled together with a boot-mode flag, the number of populated ranks, a 2-bit CAS-latency code and a bus-speed select. On a cold boot the block enables the memory clocks, keeps CKE low, and then runs the full command sequence once for each rank: a wait for the devices to power up, a NOP, CKE raised, precharges, the extended and main mode-register loads, refreshes, the final mode-register load and the two off-chip-driver steps. The DLL configuration word is strobed once, during the first pass, before any command goes out.

On a resume boot the mode-register sequence is skipped. The block strobes the DLL configuration and then issues a single wake command. In both cases it then raises its done output and presents refresh-interval code 3 (the 7.8 us interval). All delays are counted in clock cycles and set by parameters, so a system integrator converts the device timings into cycles of the controller clock. A start with a rank count of zero, or one larger than the block supports, is refused and flagged.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted, and after it, before any start, clk_en_o, cke_o, cmd_vld_o, dll_vld_o, done_o and err_o are low and refresh_code_o is 0.
- R2: A cold start turns clk_en_o on at once and keeps cke_o low until the first NOP has been issued. cke_o then goes high before the first PALL. No command other than NOP is strobed while cke_o is low.
- R3: Command codes are NOP=0, PALL=1, EMRS2=2, EMRS3=3, EMRS1=4, MRS=5, AREF=6, WAKE=7. Each cold pass issues exactly this order: NOP, PALL, EMRS2, EMRS3, EMRS1, MRS, PALL, AREF, AREF, MRS, EMRS1, EMRS1.
- R4: The address field is zero on every command except three. The first MRS of a pass sets bit 8, which resets the DLL. The second MRS carries burst length 4 as 3'b010 in bits [2:0] and the CAS latency, cas_code_i plus CL_BASE, in bits [6:4]. The first of the two final EMRS1 commands sets bits [9:7] to 3'b111, the driver default.
- R5: Each pass's NOP comes at least T_PWRUP cycles after that pass starts. The first pass starts at the cycle the start is accepted; a later pass starts at the previous pass's last command. The first PALL comes at least T_CKE cycles after cke_o rises.
- R6: Every command strobe lasts exactly one cycle, and two strobes are at least T_GAP cycles apart.
- R7: The DLL-reset MRS and the following driver-default EMRS1 are at least T_DLLRST cycles apart.
- R8: Each accepted start gives exactly one single-cycle dll_vld_o pulse, before the first command. With it, dll_cfg_o equals DLL_FAST when fast_bus_i=1 and DLL_SLOW when fast_bus_i=0.
- R9: A cold start runs as many passes as rank_cnt_i. cmd_rank_o is 0 in the first pass and goes up by one in each later pass.
- R10: A resume start (resume_i=1) issues no init commands. After the DLL pulse it issues exactly one WAKE with rank 0 and address 0, and cke_o goes high with it.
- R11: done_o rises with the last command of the run and stays high until the next accepted start. refresh_code_o is 3 while done_o is high and 0 otherwise.
- R12: A start with rank_cnt_i of 0, or above MAX_RANKS, is refused: err_o goes high and no clock enable, DLL pulse or command follows. The next valid start clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| resume_i | input | 1 | 1 = resume boot, 0 = cold boot |
| rank_cnt_i | input | CNT_W | Number of populated ranks |
| cas_code_i | input | 2 | CAS-latency code, added to CL_BASE |
| fast_bus_i | input | 1 | 1 = 533 bus speed, 0 = 400 |
| clk_en_o | output | 1 | Memory clock enable |
| cke_o | output | 1 | CKE to all ranks |
| dll_vld_o | output | 1 | DLL configuration strobe |
| dll_cfg_o | output | DLL_W | DLL configuration word |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_code_o | output | 4 | Command code |
| cmd_rank_o | output | RANK_W | Target rank |
| cmd_addr_o | output | ADDR_W | Mode-register address field |
| done_o | output | 1 | Initialization complete |
| refresh_code_o | output | 2 | Refresh-interval code |
| err_o | output | 1 | Illegal rank count at start |

## Verification
The assertions watch the cycle-local rules on every clock: strobes one cycle wide, no command except NOP while CKE is low, CKE only with the clocks running, the DLL pulse never overlapping a command, the shape of the WAKE command, silence while done or in error, and the refresh code following done. Command order, address contents, per-pass rank numbering, the minimum distances between commands and the number of passes span many cycles. Only the bench scenarios show these, by logging every strobe across cold runs of several rank counts, both bus speeds, resume runs, refused starts and a reset in the middle of a run.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_PALL  = 4'd1,
    CMD_EMRS2 = 4'd2,
    CMD_EMRS3 = 4'd3,
    CMD_EMRS1 = 4'd4,
    CMD_MRS   = 4'd5,
    CMD_AREF  = 4'd6,
    CMD_WAKE  = 4'd7
  } cmd_e;

  typedef enum logic [1:0] {
    DLY_GAP,
    DLY_CKE,
    DLY_DLL
  } dly_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAKE,
    ST_DONE
  } st_e;

  localparam int STEP_W    = 4;
  localparam int STEP_LAST = 12;

endpackage

// File: rtl/init_cmd_table.sv
module init_cmd_table
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int CL_BASE = 3
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [1:0]        cas_i,
  output cmd_e              code_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_step_o,
  output dly_e              dly_o
);

  logic [2:0] cl_val;
  assign cl_val = {1'b0, cas_i} + 3'(CL_BASE);

  always_comb begin
    code_o     = CMD_NOP;
    addr_o     = '0;
    cke_step_o = 1'b0;
    dly_o      = DLY_GAP;
    case (step_i)
      4'd0:  code_o = CMD_NOP;
      4'd1:  begin cke_step_o = 1'b1; dly_o = DLY_CKE; end
      4'd2:  code_o = CMD_PALL;
      4'd3:  code_o = CMD_EMRS2;
      4'd4:  code_o = CMD_EMRS3;
      4'd5:  code_o = CMD_EMRS1;
      4'd6:  begin code_o = CMD_MRS; addr_o[8] = 1'b1; end
      4'd7:  code_o = CMD_PALL;
      4'd8:  code_o = CMD_AREF;
      4'd9:  code_o = CMD_AREF;
      4'd10: begin
        code_o      = CMD_MRS;
        addr_o[2:0] = 3'b010;
        addr_o[6:4] = cl_val;
        dly_o       = DLY_DLL;
      end
      4'd11: begin code_o = CMD_EMRS1; addr_o[9:7] = 3'b111; end
      4'd12: code_o = CMD_EMRS1;
      default: code_o = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int          MAX_RANKS = 4,
  parameter int          ADDR_W    = 13,
  parameter int          DLL_W     = 8,
  parameter int          CL_BASE   = 3,
  parameter int          T_PWRUP   = 25000,
  parameter int          T_CKE     = 50,
  parameter int          T_GAP     = 4,
  parameter int          T_DLLRST  = 200,
  parameter logic [7:0]  DLL_FAST  = 8'h3A,
  parameter logic [7:0]  DLL_SLOW  = 8'h5C,
  localparam int         RANK_W    = $clog2(MAX_RANKS),
  localparam int         CNT_W     = $clog2(MAX_RANKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              resume_i,
  input  logic [CNT_W-1:0]  rank_cnt_i,
  input  logic [1:0]        cas_code_i,
  input  logic              fast_bus_i,
  output logic              clk_en_o,
  output logic              cke_o,
  output logic              dll_vld_o,
  output logic [DLL_W-1:0]  dll_cfg_o,
  output logic              cmd_vld_o,
  output logic [3:0]        cmd_code_o,
  output logic [RANK_W-1:0] cmd_rank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              done_o,
  output logic [1:0]        refresh_code_o,
  output logic              err_o
);

  localparam int MAX_A  = (T_PWRUP > T_DLLRST) ? T_PWRUP : T_DLLRST;
  localparam int MAX_B  = (T_CKE > T_GAP) ? T_CKE : T_GAP;
  localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_D + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  st_e               st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [RANK_W-1:0] rank_q, rank_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        cas_q, cas_d;
  logic              cke_q, cke_d, clken_q, clken_d;
  logic              done_q, done_d, err_q, err_d;
  logic [1:0]        rfc_q, rfc_d;
  logic              vld_q, vld_d, dvld_q, dvld_d;
  logic [3:0]        code_q, code_d;
  logic [RANK_W-1:0] crank_q, crank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DLL_W-1:0]  dll_q, dll_d;

  logic              tmr_ld, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  cmd_e              tbl_code;
  logic [ADDR_W-1:0] tbl_addr;
  logic              tbl_cke;
  dly_e              tbl_dly;

  init_cmd_table #(.ADDR_W(ADDR_W), .CL_BASE(CL_BASE)) u_table (
    .step_i     (step_q),
    .cas_i      (cas_q),
    .code_o     (tbl_code),
    .addr_o     (tbl_addr),
    .cke_step_o (tbl_cke),
    .dly_o      (tbl_dly)
  );

  init_gap_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  logic             accept, cnt_bad, last_pass;
  logic [CNT_W-1:0] pass_nxt;

  assign accept    = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign cnt_bad   = (rank_cnt_i == '0) || (rank_cnt_i > CNT_W'(MAX_RANKS));
  assign pass_nxt  = CNT_W'(rank_q) + 1'b1;
  assign last_pass = (pass_nxt == cnt_q);

  always_comb begin
    st_d = st_q;  step_d = step_q;  rank_d = rank_q;  cnt_d = cnt_q;
    cas_d = cas_q;  cke_d = cke_q;  clken_d = clken_q;  done_d = done_q;
    err_d = err_q;  rfc_d = rfc_q;  vld_d = 1'b0;  dvld_d = 1'b0;
    code_d = code_q;  crank_d = crank_q;  addr_d = addr_q;  dll_d = dll_q;
    tmr_ld = 1'b0;  tmr_val = '0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (accept && cnt_bad) begin
          err_d = 1'b1;
        end else if (accept) begin
          err_d   = 1'b0;
          done_d  = 1'b0;
          rfc_d   = 2'b00;
          cnt_d   = rank_cnt_i;
          cas_d   = cas_code_i;
          rank_d  = '0;
          step_d  = '0;
          cke_d   = 1'b0;
          clken_d = 1'b1;
          dvld_d  = 1'b1;
          dll_d   = fast_bus_i ? DLL_W'(DLL_FAST) : DLL_W'(DLL_SLOW);
          tmr_ld  = 1'b1;
          if (resume_i) begin
            st_d    = ST_WAKE;
            tmr_val = TMR_W'(T_GAP - 1);
          end else begin
            st_d    = ST_RUN;
            tmr_val = TMR_W'(T_PWRUP - 1);
          end
        end
      end
      ST_RUN: begin
        if (tmr_zero) begin
          tmr_ld = 1'b1;
          if (tbl_cke) begin
            cke_d = 1'b1;
          end else begin
            vld_d   = 1'b1;
            code_d  = tbl_code;
            addr_d  = tbl_addr;
            crank_d = rank_q;
          end
          unique case (tbl_dly)
            DLY_CKE: tmr_val = TMR_W'(T_CKE - 1);
            DLY_DLL: tmr_val = TMR_W'(T_DLLRST - 1);
            default: tmr_val = TMR_W'(T_GAP - 1);
          endcase
          if (step_q == STEP_W'(STEP_LAST)) begin
            step_d = '0;
            if (last_pass) begin
              st_d   = ST_DONE;
              done_d = 1'b1;
              rfc_d  = 2'b11;
            end else begin
              rank_d  = rank_q + 1'b1;
              tmr_val = TMR_W'(T_PWRUP - 1);
            end
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      ST_WAKE: begin
        if (tmr_zero) begin
          vld_d   = 1'b1;
          code_d  = CMD_WAKE;
          addr_d  = '0;
          crank_d = '0;
          cke_d   = 1'b1;
          st_d    = ST_DONE;
          done_d  = 1'b1;
          rfc_d   = 2'b11;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  step_q <= '0;  rank_q <= '0;  cnt_q <= '0;
      cas_q <= '0;  cke_q <= 1'b0;  clken_q <= 1'b0;  done_q <= 1'b0;
      err_q <= 1'b0;  rfc_q <= 2'b00;  vld_q <= 1'b0;  dvld_q <= 1'b0;
      code_q <= '0;  crank_q <= '0;  addr_q <= '0;  dll_q <= '0;
    end else begin
      st_q <= st_d;  step_q <= step_d;  rank_q <= rank_d;  cnt_q <= cnt_d;
      cas_q <= cas_d;  cke_q <= cke_d;  clken_q <= clken_d;  done_q <= done_d;
      err_q <= err_d;  rfc_q <= rfc_d;  vld_q <= vld_d;  dvld_q <= dvld_d;
      code_q <= code_d;  crank_q <= crank_d;  addr_q <= addr_d;  dll_q <= dll_d;
    end
  end

  assign clk_en_o       = clken_q;
  assign cke_o          = cke_q;
  assign dll_vld_o      = dvld_q;
  assign dll_cfg_o      = dll_q;
  assign cmd_vld_o      = vld_q;
  assign cmd_code_o     = code_q;
  assign cmd_rank_o     = crank_q;
  assign cmd_addr_o     = addr_q;
  assign done_o         = done_q;
  assign refresh_code_o = rfc_q;
  assign err_o          = err_q;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk
  import ddr2_init_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_o,
  input logic              cke_o,
  input logic              dll_vld_o,
  input logic              cmd_vld_o,
  input logic [3:0]        cmd_code_o,
  input logic [RANK_W-1:0] cmd_rank_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic              done_o,
  input logic [1:0]        refresh_code_o,
  input logic              err_o
);

  p_strobe_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |=> !cmd_vld_o);

  p_cke_has_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |-> clk_en_o);

  p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_code_o != CMD_NOP) |-> cke_o);

  p_dll_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dll_vld_o |=> !dll_vld_o);

  p_dll_no_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dll_vld_o |-> !cmd_vld_o);

  p_wake_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_code_o == CMD_WAKE) |-> (cmd_rank_o == '0 && cmd_addr_o == '0));

  p_refresh_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> refresh_code_o == 2'b11);

  p_refresh_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> refresh_code_o == 2'b00);

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> !cmd_vld_o);

  p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!cmd_vld_o && !dll_vld_o));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.RANK_W(RANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clk_en_o       (clk_en_o),
  .cke_o          (cke_o),
  .dll_vld_o      (dll_vld_o),
  .cmd_vld_o      (cmd_vld_o),
  .cmd_code_o     (cmd_code_o),
  .cmd_rank_o     (cmd_rank_o),
  .cmd_addr_o     (cmd_addr_o),
  .done_o         (done_o),
  .refresh_code_o (refresh_code_o),
  .err_o          (err_o)
);

// File: tb/ddr2_init_seq_bench.sv
module ddr2_init_seq_bench;

  localparam int MAXR  = 4;
  localparam int AW    = 13;
  localparam int CLB   = 3;
  localparam int TPW   = 40;
  localparam int TCK   = 8;
  localparam int TG    = 3;
  localparam int TDL   = 24;
  localparam int DFAST = 8'h3A;
  localparam int DSLOW = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, resume_i = 1'b0, fast_bus_i = 1'b0;
  logic [2:0] rank_cnt_i = 3'd0;
  logic [1:0] cas_code_i = 2'd0;
  logic       clk_en_o, cke_o, dll_vld_o, cmd_vld_o, done_o, err_o;
  logic [7:0] dll_cfg_o;
  logic [3:0] cmd_code_o;
  logic [1:0] cmd_rank_o;
  logic [AW-1:0] cmd_addr_o;
  logic [1:0] refresh_code_o;

  ddr2_init_seq #(
    .MAX_RANKS(MAXR), .ADDR_W(AW), .DLL_W(8), .CL_BASE(CLB), .T_PWRUP(TPW),
    .T_CKE(TCK), .T_GAP(TG), .T_DLLRST(TDL), .DLL_FAST(8'h3A), .DLL_SLOW(8'h5C)
  ) u_ddr2_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
    .rank_cnt_i(rank_cnt_i), .cas_code_i(cas_code_i), .fast_bus_i(fast_bus_i),
    .clk_en_o(clk_en_o), .cke_o(cke_o), .dll_vld_o(dll_vld_o), .dll_cfg_o(dll_cfg_o),
    .cmd_vld_o(cmd_vld_o), .cmd_code_o(cmd_code_o), .cmd_rank_o(cmd_rank_o),
    .cmd_addr_o(cmd_addr_o), .done_o(done_o), .refresh_code_o(refresh_code_o),
    .err_o(err_o)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int n_cmd, dll_n, dll_val, dll_cyc, cke_rise, st_cyc, rfc_first;
  int log_code[64], log_rank[64], log_addr[64], log_cyc[64];
  bit multi, prev_vld, prev_cke;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmd_vld_o) begin
      if (prev_vld) multi = 1'b1;
      if (n_cmd == 0) rfc_first = int'(refresh_code_o);
      if (n_cmd < 64) begin
        log_code[n_cmd] = int'(cmd_code_o);
        log_rank[n_cmd] = int'(cmd_rank_o);
        log_addr[n_cmd] = int'(cmd_addr_o);
        log_cyc[n_cmd]  = cyc;
      end
      n_cmd = n_cmd + 1;
    end
    prev_vld = cmd_vld_o;
    if (dll_vld_o) begin
      dll_n = dll_n + 1; dll_val = int'(dll_cfg_o); dll_cyc = cyc;
    end
    if (cke_o && !prev_cke) cke_rise = cyc;
    prev_cke = cke_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk);
    n_cmd = 0; dll_n = 0; dll_val = -1; dll_cyc = -1; cke_rise = -1;
    multi = 1'b0; rfc_first = -1;
  endtask

  function automatic int exp_code(input int i);
    case (i)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 4;  5: return 5;  6: return 1;  7: return 6;
      8: return 6;  9: return 5;  10: return 4; default: return 4;
    endcase
  endfunction

  function automatic int exp_addr(input int i, input int cas);
    case (i)
      5:  return 32'h100;
      9:  return (((cas + CLB) & 7) << 4) | 2;
      10: return 32'h380;
      default: return 0;
    endcase
  endfunction

  task automatic pulse_start(input bit res, input int nr, input int cas, input bit fast);
    @(negedge clk);
    resume_i = res; rank_cnt_i = 3'(nr); cas_code_i = 2'(cas); fast_bus_i = fast;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    st_cyc = cyc;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!clk_en_o && !cke_o && !cmd_vld_o && !dll_vld_o, "R1 idle outputs", int'(clk_en_o), 0);
    chk(!done_o && !err_o && refresh_code_o == 2'b00, "R1 done/err/refresh", int'(done_o), 0);
  endtask

  task automatic t_cold(input int nr, input int cas, input bit fast);
    clear_log();
    pulse_start(1'b0, nr, cas, fast);
    wait_done();
    repeat (4) @(negedge clk);
    chk(done_o == 1'b1, "R11 done after cold run", int'(done_o), 1);
    chk(refresh_code_o == 2'b11, "R11 refresh code", int'(refresh_code_o), 3);
    chk(rfc_first == 0, "R11 refresh zero mid-run", rfc_first, 0);
    chk(!err_o, "R12 err cleared by valid start", int'(err_o), 0);
    chk(clk_en_o, "R2 clocks on", int'(clk_en_o), 1);
    chk(n_cmd == 12 * nr, "R9 pass count", n_cmd, 12 * nr);
    chk(!multi, "R6 single-cycle strobes", int'(multi), 0);
    chk(dll_n == 1, "R8 one dll pulse", dll_n, 1);
    chk(dll_val == (fast ? DFAST : DSLOW), "R8 dll value", dll_val, fast ? DFAST : DSLOW);
    if (n_cmd == 12 * nr) begin
      chk(dll_cyc < log_cyc[0], "R8 dll before first command", dll_cyc, log_cyc[0]);
      chk(cke_rise > log_cyc[0], "R2 cke rises after NOP", cke_rise, log_cyc[0]);
      chk(log_cyc[1] - cke_rise >= TCK, "R5 cke to PALL", log_cyc[1] - cke_rise, TCK);
      chk(log_cyc[0] - st_cyc >= TPW, "R5 power-up wait pass 0", log_cyc[0] - st_cyc, TPW);
      for (int i = 0; i < 12 * nr; i++) begin
        chk(log_code[i] == exp_code(i % 12), "R3 command order", log_code[i], exp_code(i % 12));
        chk(log_addr[i] == exp_addr(i % 12, cas), "R4 address field", log_addr[i], exp_addr(i % 12, cas));
        chk(log_rank[i] == i / 12, "R9 rank select", log_rank[i], i / 12);
        if (i > 0)
          chk(log_cyc[i] - log_cyc[i-1] >= TG, "R6 command gap", log_cyc[i] - log_cyc[i-1], TG);
      end
      for (int r = 0; r < nr; r++) begin
        chk(log_cyc[12*r+10] - log_cyc[12*r+5] >= TDL, "R7 DLL reset to OCD default",
            log_cyc[12*r+10] - log_cyc[12*r+5], TDL);
        if (r > 0)
          chk(log_cyc[12*r] - log_cyc[12*r-1] >= TPW, "R5 power-up wait later pass",
              log_cyc[12*r] - log_cyc[12*r-1], TPW);
      end
    end
  endtask

  task automatic t_resume(input bit fast);
    clear_log();
    pulse_start(1'b1, 2, 1, fast);
    wait_done();
    repeat (4) @(negedge clk);
    chk(done_o && refresh_code_o == 2'b11, "R11 done after resume", int'(refresh_code_o), 3);
    chk(n_cmd == 1, "R10 single command", n_cmd, 1);
    chk(log_code[0] == 7 && log_rank[0] == 0 && log_addr[0] == 0, "R10 wake command", log_code[0], 7);
    chk(dll_n == 1 && dll_cyc < log_cyc[0], "R10 dll before wake", dll_n, 1);
    chk(dll_val == (fast ? DFAST : DSLOW), "R8 resume dll value", dll_val, fast ? DFAST : DSLOW);
    chk(cke_o, "R10 cke high after wake", int'(cke_o), 1);
  endtask

  task automatic t_bad_count(input int nr, input bit exp_clk);
    clear_log();
    pulse_start(1'b0, nr, 0, 1'b0);
    repeat (TPW + 20) @(negedge clk);
    chk(err_o, "R12 error flag", int'(err_o), 1);
    chk(n_cmd == 0 && dll_n == 0, "R12 no commands or dll", n_cmd + dll_n, 0);
    chk(clk_en_o == exp_clk, "R12 clock enable unchanged", int'(clk_en_o), int'(exp_clk));
  endtask

  task automatic t_mid_reset();
    clear_log();
    pulse_start(1'b0, 2, 0, 1'b1);
    repeat (TPW + 30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!clk_en_o && !cke_o && !done_o && !cmd_vld_o, "R1 reset mid-run", int'(cke_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!clk_en_o && !cke_o && !done_o && refresh_code_o == 2'b00, "R1 idle after reset", int'(clk_en_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!clk_en_o && !cke_o && !done_o, "R1 during reset", int'(clk_en_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bad_count(0, 1'b0);
    t_bad_count(5, 1'b0);
    t_cold(1, 0, 1'b0);
    t_cold(3, 2, 1'b1);
    t_bad_count(0, 1'b1);
    t_cold(4, 3, 1'b0);
    t_resume(1'b1);
    t_resume(1'b0);
    t_cold(2, 1, 1'b1);
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule